// File: doc/BRIEF.md
# UART Transmitter with XON/XOFF Control

This block serialises characters onto an asynchronous serial line. Software or a DMA engine streams 32-bit words into an eight-word queue over a valid/ready port. Each word carries four characters, and the block sends them lowest byte first. A one-cycle `bit_en` pulse from an external bit-rate divider marks every bit boundary. Frame shape is set by plain configuration pins: character length (5 to 8 bits), optional odd or even parity, and one or two stop bits. The line can also be held in a break condition.

Transmission is gated three ways, and every gate acts only at a character boundary, so a character that has started always completes:
- a pause state, set and cleared by XOFF/XON character-match pulses from a companion receiver or by software pulses;
- an optional clear-to-send input;
- a halt control that freezes the transmitter.

A single injected character can be handed in through a one-entry side port. It goes out the next time the transmitter is idle, ahead of queued data. It ignores the pause state and clear-to-send, so flow-control characters can still be sent while the stream is held.

Back-pressure rules for the stream port:
- A word transfers on any clock edge where both `s_valid` and `s_ready` are high.
- `s_ready` depends only on queue occupancy, never on `s_valid`.
- The source may hold `s_valid` and `s_data` for any number of cycles.

The injection port follows the same valid/ready rules.

Top module: `uart_xoff_tx`

## Requirements
- R1: The queue holds 8 words. `s_ready` is high exactly when fewer than 8 words still hold unsent characters. Characters of a word leave as bits [7:0], then [15:8], then [23:16], then [31:24]. A word's slot frees on the clock edge where its last character starts.
- R2: After reset, `txd`=1, `tx_busy`=0, `tx_paused`=0, `s_ready`=1 and `force_ready`=1.
- R3: A frame is a 0 start bit, then `cfg_word_len`+5 data bits LSB first (bits above the length are ignored), then, if `cfg_par_en`=1, a parity bit, then one stop bit of value 1, or two if `cfg_two_stop`=1. With `cfg_par_odd`=0 the number of ones across data and parity is even; with 1 it is odd. Configuration is taken when the start bit begins.
- R4: `txd` and `tx_busy` change only on cycles with `bit_en`=1, and each bit lasts from one such cycle to the next. A queued character starts on the same pulse that ends the previous last stop bit. `tx_busy` is 0 only while the line idles high.
- R5: A pulse on `xoff_hit` or `sw_xoff` sets `tx_paused` on the next edge. A pulse on `xon_hit` or `sw_xon` clears it, unless an off request arrives in the same cycle, in which case the off request wins. While paused, no queued character starts, but a character already started completes.
- R6: With `cfg_cts_en`=1 and `cts_n`=1, no queued character starts, but a started character completes. With `cfg_cts_en`=0, `cts_n` has no effect.
- R7: `force_valid`/`force_ready` loads a one-entry holding register, and `force_ready` is low while it is full. The held character starts only from the idle state, never back to back after another frame. It takes priority over queued data and ignores the pause state and clear-to-send.
- R8: While `force_halt`=1, no frame and no break starts. A frame or break already running completes.
- R9: If `cfg_break`=1 at a start opportunity and the transmitter is not halted, `txd` goes to 0 and stays 0 until the first `bit_en` pulse with `cfg_break`=0. It is then 1 for the configured number of stop bits before anything else starts. Break takes priority over characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle pulse per bit time |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Queue can accept a word |
| s_data | input | 32 | Four characters, low byte sent first |
| cfg_word_len | input | 2 | Character length minus 5 |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_par_en | input | 1 | Append parity bit |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_break | input | 1 | Request a break on the line |
| cfg_cts_en | input | 1 | Honour clear-to-send |
| cts_n | input | 1 | Clear-to-send, active low |
| xon_hit | input | 1 | Receiver matched the resume character |
| xoff_hit | input | 1 | Receiver matched the pause character |
| sw_xon | input | 1 | Software resume pulse |
| sw_xoff | input | 1 | Software pause pulse |
| force_halt | input | 1 | Freeze: no new frame or break starts |
| force_valid | input | 1 | Injected character valid |
| force_ready | output | 1 | Holding register empty |
| force_char | input | 8 | Injected character |
| txd | output | 1 | Serial line |
| tx_busy | output | 1 | Frame or break in progress |
| tx_paused | output | 1 | Pause state |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a pause request and the acceptance of an injected character. The bench raises `xoff_hit` on the same edge that `force_valid` is accepted while a queued stream is running. It then expects the current frame to finish, the injected character to go out from idle, and no queued character to follow.

The second pair is opposite flow-control events: a resume pulse on one source and a pause pulse on the other in the same cycle, where the pause must win. The behavioural reference model in the bench predicts `txd`, `tx_busy`, `tx_paused`, `s_ready` and `force_ready` on every clock, and every clock is compared against it.

// File: rtl/uart_xoff_tx_pkg.sv
package uart_xoff_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRK
  } tx_state_e;

  typedef struct packed {
    logic [1:0] word_len;
    logic       two_stop;
    logic       par_en;
    logic       par_odd;
  } frame_cfg_t;

  // Mask of the data bits that belong to a character of the given length.
  function automatic logic [7:0] len_mask(input logic [1:0] wl);
    return 8'hFF >> (2'd3 - wl);
  endfunction

  // Parity bit for a character under a given frame configuration.
  function automatic logic frame_parity(input logic [7:0] d, input frame_cfg_t c);
    return c.par_odd ^ (^(d & len_mask(c.word_len)));
  endfunction

endpackage

// File: rtl/txq_word_fifo.sv
module txq_word_fifo #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  output logic              space,
  input  logic              pop_char,
  output logic              char_avail,
  output logic [7:0]        char_out
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int LANES = WORD_W / 8;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic [LANE_W-1:0] lane;
  logic              last_lane, do_push, free_slot;
  logic [7:0]        lane_bytes [LANES];

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Split the head word into byte lanes.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bytes[g] = mem[rd_ptr][8*g +: 8];
  end

  assign space      = (count < CNT_W'(DEPTH));
  assign char_avail = (count != '0);
  assign char_out   = lane_bytes[lane];
  assign last_lane  = (lane == LANE_W'(LANES - 1));
  assign do_push    = push && space;
  assign free_slot  = pop_char && char_avail && last_lane;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      lane   <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (pop_char && char_avail) begin
        if (last_lane) begin
          lane   <= '0;
          rd_ptr <= ptr_next(rd_ptr);
        end else begin
          lane <= lane + 1'b1;
        end
      end
      case ({do_push, free_slot})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/txq_flow_arb.sv
module txq_flow_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boundary,
  input  logic       from_idle,
  input  logic       halt,
  input  logic       brk_req,
  input  logic       cts_en,
  input  logic       cts_n,
  input  logic       xon_evt,
  input  logic       xoff_evt,
  input  logic       fifo_avail,
  input  logic [7:0] fifo_char,
  input  logic       force_valid,
  input  logic [7:0] force_char,
  output logic       force_ready,
  output logic       paused,
  output logic       go_brk,
  output logic       go_char,
  output logic       pop_fifo,
  output logic [7:0] char_sel
);
  logic       paused_q, fpend_q;
  logic [7:0] fchar_q;
  logic       launch_ok, take_force, cts_ok;

  assign cts_ok     = !cts_en || !cts_n;
  assign launch_ok  = boundary && !halt;
  assign go_brk     = launch_ok && brk_req;
  assign take_force = launch_ok && !brk_req && fpend_q && from_idle;
  assign pop_fifo   = launch_ok && !brk_req && !take_force && fifo_avail
                      && !paused_q && cts_ok;
  assign go_char    = take_force || pop_fifo;
  assign char_sel   = take_force ? fchar_q : fifo_char;

  assign force_ready = !fpend_q;
  assign paused      = paused_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paused_q <= 1'b0;
      fpend_q  <= 1'b0;
      fchar_q  <= '0;
    end else begin
      if (xoff_evt)     paused_q <= 1'b1;
      else if (xon_evt) paused_q <= 1'b0;

      if (take_force) begin
        fpend_q <= 1'b0;
      end else if (force_valid && !fpend_q) begin
        fpend_q <= 1'b1;
        fchar_q <= force_char;
      end
    end
  end
endmodule

// File: rtl/txq_frame_ser.sv
module txq_frame_ser
  import uart_xoff_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  frame_cfg_t cfg,
  input  logic       cfg_break,
  input  logic       go_brk,
  input  logic       go_char,
  input  logic [7:0] char_in,
  output logic       boundary,
  output logic       at_idle,
  output logic       txd
);
  tx_state_e  st;
  frame_cfg_t cur;
  logic [7:0] shreg;
  logic [2:0] bit_idx;
  logic       stop_idx, par_q, txd_q;
  logic       stop_last, data_last;

  assign stop_last = (stop_idx == cur.two_stop);
  assign data_last = (bit_idx == (3'd4 + {1'b0, cur.word_len}));
  assign at_idle   = (st == ST_IDLE);
  assign boundary  = tick && (at_idle || (st == ST_STOP && stop_last));
  assign txd       = txd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur      <= '0;
      shreg    <= '0;
      bit_idx  <= '0;
      stop_idx <= 1'b0;
      par_q    <= 1'b0;
      txd_q    <= 1'b1;
    end else if (tick) begin
      unique case (st)
        ST_START: begin
          txd_q   <= shreg[0];
          bit_idx <= '0;
          st      <= ST_DATA;
        end
        ST_DATA: begin
          if (data_last) begin
            if (cur.par_en) begin
              st    <= ST_PAR;
              txd_q <= par_q;
            end else begin
              st       <= ST_STOP;
              txd_q    <= 1'b1;
              stop_idx <= 1'b0;
            end
          end else begin
            bit_idx <= bit_idx + 1'b1;
            txd_q   <= shreg[1];
            shreg   <= shreg >> 1;
          end
        end
        ST_PAR: begin
          st       <= ST_STOP;
          txd_q    <= 1'b1;
          stop_idx <= 1'b0;
        end
        ST_BRK: begin
          if (!cfg_break) begin
            st           <= ST_STOP;
            txd_q        <= 1'b1;
            stop_idx     <= 1'b0;
            cur.two_stop <= cfg.two_stop;
          end else begin
            txd_q <= 1'b0;
          end
        end
        default: begin
          if (st == ST_STOP && !stop_last) begin
            stop_idx <= 1'b1;
            txd_q    <= 1'b1;
          end else if (go_brk) begin
            st    <= ST_BRK;
            txd_q <= 1'b0;
          end else if (go_char) begin
            st    <= ST_START;
            txd_q <= 1'b0;
            shreg <= char_in;
            cur   <= cfg;
            par_q <= frame_parity(char_in, cfg);
          end else begin
            st    <= ST_IDLE;
            txd_q <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/uart_xoff_tx.sv
module uart_xoff_tx
  import uart_xoff_tx_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  input  logic [1:0]        cfg_word_len,
  input  logic              cfg_two_stop,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_break,
  input  logic              cfg_cts_en,
  input  logic              cts_n,
  input  logic              xon_hit,
  input  logic              xoff_hit,
  input  logic              sw_xon,
  input  logic              sw_xoff,
  input  logic              force_halt,
  input  logic              force_valid,
  output logic              force_ready,
  input  logic [7:0]        force_char,
  output logic              txd,
  output logic              tx_busy,
  output logic              tx_paused
);
  frame_cfg_t cfg;
  logic       fifo_avail, pop_fifo, boundary, at_idle, go_brk, go_char;
  logic [7:0] fifo_char, char_sel;

  assign cfg = '{word_len: cfg_word_len, two_stop: cfg_two_stop,
                 par_en: cfg_par_en, par_odd: cfg_par_odd};

  txq_word_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(s_valid), .push_data(s_data),
    .space(s_ready), .pop_char(pop_fifo), .char_avail(fifo_avail),
    .char_out(fifo_char)
  );

  txq_flow_arb u_arb (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .from_idle(at_idle),
    .halt(force_halt), .brk_req(cfg_break), .cts_en(cfg_cts_en),
    .cts_n(cts_n), .xon_evt(xon_hit || sw_xon),
    .xoff_evt(xoff_hit || sw_xoff), .fifo_avail(fifo_avail),
    .fifo_char(fifo_char), .force_valid(force_valid),
    .force_char(force_char), .force_ready(force_ready),
    .paused(tx_paused), .go_brk(go_brk), .go_char(go_char),
    .pop_fifo(pop_fifo), .char_sel(char_sel)
  );

  txq_frame_ser u_ser (
    .clk(clk), .rst_n(rst_n), .tick(bit_en), .cfg(cfg),
    .cfg_break(cfg_break), .go_brk(go_brk), .go_char(go_char),
    .char_in(char_sel), .boundary(boundary), .at_idle(at_idle),
    .txd(txd)
  );

  assign tx_busy = !at_idle;
endmodule

// File: rtl/uart_xoff_tx_chk.sv
module uart_xoff_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic cfg_break,
  input logic xon_hit,
  input logic xoff_hit,
  input logic sw_xon,
  input logic sw_xoff,
  input logic force_halt,
  input logic force_valid,
  input logic force_ready,
  input logic txd,
  input logic tx_busy,
  input logic tx_paused
);
  // R2: idle line is high
  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  // R4: line moves only on bit pulses
  a_r4_txd_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(txd));

  a_r4_busy_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_busy));

  // R5: pause set, off request wins
  a_r5_pause_set: assert property (@(posedge clk) disable iff (!rst_n)
    (xoff_hit || sw_xoff) |=> tx_paused);

  a_r5_pause_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((xon_hit || sw_xon) && !(xoff_hit || sw_xoff)) |=> !tx_paused);

  // R7: holding register fills on handshake
  a_r7_force_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (force_valid && force_ready) |=> !force_ready);

  // R8: halted idle transmitter stays idle
  a_r8_halt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (force_halt && !tx_busy) |=> !tx_busy);

  // R9: break from idle drives the line low
  a_r9_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_break && !tx_busy && bit_en && !force_halt) |=> !txd);
endmodule

bind uart_xoff_tx uart_xoff_tx_chk u_chk (.*);

// File: tb/uart_xoff_tx_test.sv
`timescale 1ns/1ps
module uart_xoff_tx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic [1:0]  cfg_word_len = 2'd3;
  logic        cfg_two_stop = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic        cfg_break = 1'b0, cfg_cts_en = 1'b0, cts_n = 1'b0;
  logic        xon_hit = 1'b0, xoff_hit = 1'b0, sw_xon = 1'b0, sw_xoff = 1'b0;
  logic        force_halt = 1'b0, force_valid = 1'b0;
  logic [7:0]  force_char = '0;
  logic        s_ready, force_ready, txd, tx_busy, tx_paused;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R3";
  logic [1:0] be_cnt = '0;

  always #4 clk = ~clk;

  uart_xoff_tx uut (.*);

  // ---------------- reference model ----------------
  bit [7:0] mq[$];
  bit       mf[$];
  int       m_mode;            // 0 idle, 1 frame, 2 break
  bit       m_txd, m_paused, m_fpend;
  bit [7:0] m_fchar;
  bit       old_pend, old_paused, bnd, fidle;
  int       occ_old;

  function automatic int m_occ();
    return (mq.size() + 3) / 4;
  endfunction

  function automatic void build(input bit [7:0] c);
    bit p;
    p = cfg_par_odd;
    m_mode = 1;
    m_txd  = 1'b0;
    for (int i = 0; i < 5 + int'(cfg_word_len); i++) begin
      mf.push_back(c[i]);
      p ^= c[i];
    end
    if (cfg_par_en) mf.push_back(p);
    mf.push_back(1'b1);
    if (cfg_two_stop) mf.push_back(1'b1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); mf.delete();
      m_mode = 0; m_txd = 1; m_paused = 0; m_fpend = 0; m_fchar = '0;
    end else begin
      old_pend = m_fpend;
      old_paused = m_paused;
      occ_old = m_occ();
      if (bit_en) begin
        bnd = 0; fidle = 0;
        case (m_mode)
          0: begin bnd = 1; fidle = 1; end
          1: if (mf.size() > 0) m_txd = mf.pop_front(); else bnd = 1;
          default: begin
            if (!cfg_break) begin
              m_mode = 1; m_txd = 1;
              if (cfg_two_stop) mf.push_back(1'b1);
            end else m_txd = 0;
          end
        endcase
        if (bnd) begin
          if (force_halt) begin m_mode = 0; m_txd = 1; end
          else if (cfg_break) begin m_mode = 2; m_txd = 0; end
          else if (old_pend && fidle) begin build(m_fchar); m_fpend = 0; end
          else if (mq.size() > 0 && !old_paused && (!cfg_cts_en || !cts_n))
            build(mq.pop_front());
          else begin m_mode = 0; m_txd = 1; end
        end
      end
      if (force_valid && !old_pend) begin m_fpend = 1; m_fchar = force_char; end
      if (s_valid && occ_old < 8)
        for (int b = 0; b < 4; b++) mq.push_back(s_data[8*b +: 8]);
      if (xoff_hit || sw_xoff) m_paused = 1;
      else if (xon_hit || sw_xon) m_paused = 0;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // bit pulse every 4 clocks, driven away from the active edge
  always @(negedge clk) begin
    be_cnt <= be_cnt + 1'b1;
    bit_en <= (be_cnt == 2'd3);
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " txd"}, txd, m_txd);
      chk("R4 tx_busy", tx_busy, m_mode != 0);
      chk("R1 s_ready", s_ready, m_occ() < 8);
      chk("R7 force_ready", force_ready, !m_fpend);
      chk("R5 tx_paused", tx_paused, m_paused);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_word(input logic [31:0] w);
    @(negedge clk); s_valid = 1'b1; s_data = w;
    while (!s_ready) @(negedge clk);
    @(negedge clk); s_valid = 1'b0;
  endtask

  task automatic inject(input logic [7:0] c);
    @(negedge clk); force_valid = 1'b1; force_char = c;
    while (!force_ready) @(negedge clk);
    @(negedge clk); force_valid = 1'b0;
  endtask

  task automatic wait_drain();
    @(negedge clk);
    while (m_mode != 0 || mq.size() != 0 || m_fpend) @(negedge clk);
    cyc(8);
  endtask

  task automatic set_cfg(input logic [1:0] wl, input logic two, input logic pe,
                         input logic po);
    @(negedge clk);
    cfg_word_len = wl; cfg_two_stop = two; cfg_par_en = pe; cfg_par_odd = po;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- sequence ----------------
  initial begin
    cyc(5);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset txd", txd, 1'b1);
    chk("R2 reset tx_busy", tx_busy, 1'b0);
    chk("R2 reset tx_paused", tx_paused, 1'b0);
    chk("R2 reset s_ready", s_ready, 1'b1);
    chk("R2 reset force_ready", force_ready, 1'b1);

    // R3/R1: 8N1, byte order, back to back
    cur_req = "R3";
    push_word(32'hA53C0F81);
    push_word(32'h00FF7E12);
    wait_drain();

    // R3: 5 bits even parity two stop; 7 bits odd; 6 bits no parity
    set_cfg(2'd0, 1'b1, 1'b1, 1'b0);
    push_word(32'hFFE31F0A);
    wait_drain();
    set_cfg(2'd2, 1'b0, 1'b1, 1'b1);
    push_word(32'h80817F00);
    wait_drain();
    set_cfg(2'd1, 1'b0, 1'b0, 1'b0);
    push_word(32'h5AC3963C);
    wait_drain();
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);

    // R5: pause mid character, then opposite events in the same cycle
    cur_req = "R5";
    push_word(32'h44332211);
    push_word(32'h88776655);
    cyc(30);
    @(negedge clk); xoff_hit = 1'b1;
    @(negedge clk); xoff_hit = 1'b0;
    chk("R5 paused after xoff_hit", tx_paused, 1'b1);
    cyc(300);
    chk("R5 no queued start while paused", tx_busy, 1'b0);
    @(negedge clk); sw_xon = 1'b1; xoff_hit = 1'b1;
    @(negedge clk); sw_xon = 1'b0; xoff_hit = 1'b0;
    chk("R5 off request wins", tx_paused, 1'b1);
    // R7: injected character bypasses pause
    cur_req = "R7";
    inject(8'h11);
    cyc(80);
    chk("R7 injected frame done while paused", tx_busy, 1'b0);
    @(negedge clk); xon_hit = 1'b1;
    @(negedge clk); xon_hit = 1'b0;
    chk("R5 resume clears pause", tx_paused, 1'b0);
    wait_drain();

    // R6: clear-to-send gating
    cur_req = "R6";
    @(negedge clk); cfg_cts_en = 1'b1; cts_n = 1'b1;
    push_word(32'hC0FFEE01);
    cyc(200);
    chk("R6 held by cts", tx_busy, 1'b0);
    @(negedge clk); cts_n = 1'b0;
    wait_drain();
    @(negedge clk); cfg_cts_en = 1'b0; cts_n = 1'b1;
    push_word(32'h0BADF00D);
    wait_drain();
    cts_n = 1'b0;

    // R7: injection during a stream waits for idle; same cycle as xoff
    cur_req = "R7";
    push_word(32'h31323334);
    push_word(32'h41424344);
    cyc(20);
    @(negedge clk); force_valid = 1'b1; force_char = 8'h13; xoff_hit = 1'b1;
    @(negedge clk); force_valid = 1'b0; xoff_hit = 1'b0;
    chk("R7 holding register full", force_ready, 1'b0);
    cyc(200);
    chk("R7 injected sent, queue paused", force_ready, 1'b1);
    @(negedge clk); sw_xon = 1'b1;
    @(negedge clk); sw_xon = 1'b0;
    wait_drain();

    // R8: halt from idle and mid frame
    cur_req = "R8";
    @(negedge clk); force_halt = 1'b1;
    push_word(32'h12345678);
    cyc(200);
    chk("R8 halted stays idle", tx_busy, 1'b0);
    @(negedge clk); force_halt = 1'b0;
    cyc(20);
    @(negedge clk); force_halt = 1'b1;
    cyc(200);
    chk("R8 running frame completed", tx_busy, 1'b0);
    @(negedge clk); force_halt = 1'b0;
    wait_drain();

    // R9: break with two stop bits, then break behind queued data
    cur_req = "R9";
    set_cfg(2'd3, 1'b1, 1'b0, 1'b0);
    @(negedge clk); cfg_break = 1'b1;
    cyc(60);
    chk("R9 line low during break", txd, 1'b0);
    @(negedge clk); cfg_break = 1'b0;
    wait_drain();
    push_word(32'h9ABCDEF0);
    cyc(50);
    @(negedge clk); cfg_break = 1'b1;
    cyc(100);
    @(negedge clk); cfg_break = 1'b0;
    wait_drain();
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);

    // R1: fill the queue while paused
    cur_req = "R1";
    @(negedge clk); sw_xoff = 1'b1;
    @(negedge clk); sw_xoff = 1'b0;
    for (int k = 0; k < 8; k++) push_word(32'h01010101 * (k + 1));
    @(negedge clk);
    chk("R1 full after 8 words", s_ready, 1'b0);
    @(negedge clk); sw_xon = 1'b1;
    @(negedge clk); sw_xon = 1'b0;
    wait_drain();
    chk("R1 space after drain", s_ready, 1'b1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule